// File: doc/BRIEF.md
# Reorder Buffer with Shared Retire Port

This block keeps the program order of in-flight instructions in a small out-of-order core. Each dispatched instruction claims the next slot of a circular buffer, and its slot index becomes its tag. A slot holds the destination architectural register, the result value, a finished flag and a flag that marks a memory operation. Execution units report results in any order through a completion port. The oldest slot writes the architectural register file only after it has finished. This order is what lets an exception or a mis-speculation be taken precisely at the oldest slot.

One hardware port serves two users: a memory operation that is executing, and the retirement of the oldest slot. The block grants that port every cycle. A memory execute request always wins, and a pending retirement waits until a cycle in which no memory request is present. A flush input, raised when a fault is taken at the oldest slot, keeps that slot and discards every younger one. Tags younger than the faulting slot are then handed out again.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `disp_ready` is 1, `disp_tag` is 0, and both `retire_valid` and `rf_we` are 0.
- R2: A dispatch is accepted on a clock edge when `disp_valid` and `disp_ready` are high and `flush` is low. The tag shown on `disp_tag` before that edge is the slot index. Tags run 0, 1, 2, ... and wrap modulo DEPTH.
- R3: After DEPTH accepted dispatches with no retirement, `disp_ready` is 0. A dispatch offered while `disp_ready` is 0 has no effect: it takes no slot and is never retired.
- R4: On an edge where `cmpl_valid` is high and `cmpl_tag` names an occupied slot, that slot is marked finished and takes `cmpl_value`. Slots may finish in any order.
- R5: The oldest slot retires only once it is finished, at most one slot per cycle, in program order. `retire_valid` is high in the same cycle, and `rf_waddr` and `rf_wdata` carry its register and value.
- R6: `mem_exec_grant` equals `mem_exec_req` in every cycle. While `mem_exec_req` is high, `retire_valid` is 0, and a finished oldest slot retires in the first later cycle without a request.
- R7: A slot dispatched with `disp_is_mem` = 1 retires with `retire_valid` = 1 and `rf_we` = 0. Any other slot retires with `rf_we` = 1.
- R8: While `flush` is high, no slot retires and no dispatch is taken. On that edge, if the buffer is not empty, every slot except the oldest is discarded, the next tag becomes the oldest index plus one, and the discarded slots never retire. On an empty buffer a flush changes nothing.
- R9: A completion that names an unoccupied slot is ignored. A later dispatch into that slot starts unfinished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_dest | input | AREG_W | Destination architectural register |
| disp_is_mem | input | 1 | Instruction is a memory operation (no register write) |
| disp_ready | output | 1 | A slot is free |
| disp_tag | output | log2(DEPTH) | Tag the next dispatch receives |
| cmpl_valid | input | 1 | Completion report |
| cmpl_tag | input | log2(DEPTH) | Slot being completed |
| cmpl_value | input | DATA_W | Result value |
| mem_exec_req | input | 1 | A memory operation wants the shared port |
| mem_exec_grant | output | 1 | Shared port granted to the memory operation |
| flush | input | 1 | Discard all slots younger than the oldest |
| retire_valid | output | 1 | Oldest slot retires this cycle |
| retire_tag | output | log2(DEPTH) | Tag of the retiring slot |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | AREG_W | Register-file write address |
| rf_wdata | output | DATA_W | Register-file write data |

## Verification
The bench builds the buffer with DEPTH = 4. With four slots, a short sequence fills the buffer, offers a dispatch that must be refused, and drives the pointers past the index wrap while the wrap bit still tells full from empty. The small depth also lets one flush discard a younger slot that has already finished. This makes it possible to check that the discarded slot never reaches the register file and that its tag is reused at once.

// File: rtl/rob_pkg.sv
package rob_pkg;
    localparam int AREG_W = 5;
    localparam int DATA_W = 16;

    typedef struct packed {
        logic              valid;
        logic              done;
        logic              is_mem;
        logic [AREG_W-1:0] dest;
        logic [DATA_W-1:0] value;
    } rob_slot_t;
endpackage

// File: rtl/rob_port_arb.sv
module rob_port_arb (
    input  logic mem_req,
    input  logic retire_ready,
    input  logic hold,
    output logic mem_grant,
    output logic retire_go
);
    // Fixed priority: memory execute first, retirement only on an idle port.
    always_comb begin
        mem_grant = mem_req;
        retire_go = retire_ready && !mem_req && !hold;
    end
endmodule

// File: rtl/rob_occupancy.sv
module rob_occupancy #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic [PTR_W-1:0] head,
    input  logic [PTR_W-1:0] tail,
    output logic [PTR_W-1:0] count,
    output logic             full,
    output logic             empty
);
    always_comb begin
        count = tail - head;
        empty = (head == tail);
        full  = (head[IDX_W-1:0] == tail[IDX_W-1:0]) && (head[PTR_W-1] != tail[PTR_W-1]);
    end
endmodule

// File: rtl/rob_core.sv
module rob_core #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int AREG_W = rob_pkg::AREG_W,
    localparam int DATA_W = rob_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    input  logic [AREG_W-1:0] disp_dest,
    input  logic              disp_is_mem,
    output logic              disp_ready,
    output logic [IDX_W-1:0]  disp_tag,
    input  logic              cmpl_valid,
    input  logic [IDX_W-1:0]  cmpl_tag,
    input  logic [DATA_W-1:0] cmpl_value,
    input  logic              mem_exec_req,
    output logic              mem_exec_grant,
    input  logic              flush,
    output logic              retire_valid,
    output logic [IDX_W-1:0]  retire_tag,
    output logic              rf_we,
    output logic [AREG_W-1:0] rf_waddr,
    output logic [DATA_W-1:0] rf_wdata
);
    import rob_pkg::*;

    localparam int PTR_W = IDX_W + 1;

    typedef struct packed {
        logic [PTR_W-1:0]            head;
        logic [PTR_W-1:0]            tail;
        rob_slot_t [DEPTH-1:0]       slot;
    } rob_state_t;

    rob_state_t s_q, s_d;

    logic [IDX_W-1:0] head_idx, tail_idx;
    rob_slot_t        head_slot;
    logic [PTR_W-1:0] occ_count;
    logic             full, empty;
    logic             retire_ready, retire_go;

    assign head_idx     = s_q.head[IDX_W-1:0];
    assign tail_idx     = s_q.tail[IDX_W-1:0];
    assign head_slot    = s_q.slot[head_idx];
    assign retire_ready = head_slot.valid && head_slot.done;

    rob_occupancy #(.DEPTH(DEPTH)) u_occ (
        .head  (s_q.head),
        .tail  (s_q.tail),
        .count (occ_count),
        .full  (full),
        .empty (empty)
    );

    rob_port_arb u_arb (
        .mem_req      (mem_exec_req),
        .retire_ready (retire_ready),
        .hold         (flush),
        .mem_grant    (mem_exec_grant),
        .retire_go    (retire_go)
    );

    always_comb begin
        s_d = s_q;
        // Completion: only an occupied slot may finish.
        if (cmpl_valid && s_q.slot[cmpl_tag].valid) begin
            s_d.slot[cmpl_tag].done  = 1'b1;
            s_d.slot[cmpl_tag].value = cmpl_value;
        end
        // Retirement of the oldest slot.
        if (retire_go) begin
            s_d.slot[head_idx].valid = 1'b0;
            s_d.head = s_q.head + PTR_W'(1);
        end
        // Flush keeps the oldest slot, drops all younger ones; it outranks dispatch.
        if (flush) begin
            if (!empty) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (IDX_W'(i) != head_idx) begin
                        s_d.slot[i].valid = 1'b0;
                    end
                end
                s_d.tail = s_q.head + PTR_W'(1);
            end
        end else if (disp_valid && !full) begin
            s_d.slot[tail_idx].valid  = 1'b1;
            s_d.slot[tail_idx].done   = 1'b0;
            s_d.slot[tail_idx].is_mem = disp_is_mem;
            s_d.slot[tail_idx].dest   = disp_dest;
            s_d.slot[tail_idx].value  = '0;
            s_d.tail = s_q.tail + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign disp_ready   = !full;
    assign disp_tag     = tail_idx;
    assign retire_valid = retire_go;
    assign retire_tag   = head_idx;
    assign rf_we        = retire_go && !head_slot.is_mem;
    assign rf_waddr     = head_slot.dest;
    assign rf_wdata     = head_slot.value;

    // R6: the shared port never serves both users in one cycle.
    p_port_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_exec_grant && retire_valid));

    // R6: a memory request always holds off retirement.
    p_mem_priority_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_exec_req |-> (mem_exec_grant && !retire_valid));

    // R3: occupancy never exceeds the buffer depth.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        occ_count <= PTR_W'(DEPTH));

    // R8: a flush of a non-empty buffer leaves exactly the oldest slot.
    p_flush_trim_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !empty) |=> (occ_count == PTR_W'(1)));

    // R5: each retirement advances the oldest pointer by exactly one.
    p_retire_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid |=> (s_q.head == $past(s_q.head) + PTR_W'(1)));
endmodule

// File: tb/rob_core_bench.sv
module rob_core_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int AREG_W = rob_pkg::AREG_W;
    localparam int DATA_W = rob_pkg::DATA_W;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              disp_valid;
    logic [AREG_W-1:0] disp_dest;
    logic              disp_is_mem;
    logic              disp_ready;
    logic [IDX_W-1:0]  disp_tag;
    logic              cmpl_valid;
    logic [IDX_W-1:0]  cmpl_tag;
    logic [DATA_W-1:0] cmpl_value;
    logic              mem_exec_req;
    logic              mem_exec_grant;
    logic              flush;
    logic              retire_valid;
    logic [IDX_W-1:0]  retire_tag;
    logic              rf_we;
    logic [AREG_W-1:0] rf_waddr;
    logic [DATA_W-1:0] rf_wdata;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rob_core #(.DEPTH(DEPTH)) u_rob_core (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_dest(disp_dest), .disp_is_mem(disp_is_mem),
        .disp_ready(disp_ready), .disp_tag(disp_tag),
        .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag), .cmpl_value(cmpl_value),
        .mem_exec_req(mem_exec_req), .mem_exec_grant(mem_exec_grant),
        .flush(flush),
        .retire_valid(retire_valid), .retire_tag(retire_tag),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    typedef struct packed {
        logic        dv;
        logic [4:0]  dd;
        logic        dm;
        logic        cv;
        logic [1:0]  ct;
        logic [15:0] cval;
        logic        mr;
        logic        fl;
        logic        e_rdy;
        logic [1:0]  e_tag;
        logic        e_ret;
        logic        e_we;
        logic [4:0]  e_addr;
        logic [15:0] e_data;
    } vec_t;

    localparam int NVEC = 13;
    // Fill, refuse when full, out-of-order completion, store retire held by a memory request.
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 5'd0, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 5'd0, 16'h0000},
        '{1'b1, 5'd3, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 5'd0, 16'h0000},
        '{1'b1, 5'd4, 1'b1, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 5'd0, 16'h0000},
        '{1'b1, 5'd5, 1'b0, 1'b1, 2'd1, 16'hAAAA, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 5'd0, 16'h0000},
        '{1'b1, 5'd6, 1'b0, 1'b1, 2'd0, 16'h1111, 1'b0, 1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 5'd0, 16'h0000},
        '{1'b1, 5'd7, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 5'd3, 16'h1111},
        '{1'b0, 5'd0, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 5'd0, 16'h0000},
        '{1'b0, 5'd0, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 5'd0, 16'h0000},
        '{1'b0, 5'd0, 1'b0, 1'b1, 2'd3, 16'h3333, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 5'd0, 16'h0000},
        '{1'b0, 5'd0, 1'b0, 1'b1, 2'd2, 16'h2222, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 5'd0, 16'h0000},
        '{1'b0, 5'd0, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 1'b1, 5'd5, 16'h2222},
        '{1'b1, 5'd8, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 1'b1, 5'd6, 16'h3333},
        '{1'b0, 5'd0, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 5'd0, 16'h0000}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic dv, input logic [4:0] dd, input logic dm,
                         input logic cv, input logic [1:0] ct, input logic [15:0] cval,
                         input logic mr, input logic fl);
        @(posedge clk);
        #1;
        disp_valid = dv; disp_dest = dd; disp_is_mem = dm;
        cmpl_valid = cv; cmpl_tag = ct; cmpl_value = cval;
        mem_exec_req = mr; flush = fl;
        @(negedge clk);
    endtask

    task automatic expect_ret(input string req, input logic ret, input logic we,
                              input logic [4:0] addr, input logic [15:0] data);
        chk(req, "retire_valid", int'(retire_valid), int'(ret));
        chk(req, "rf_we", int'(rf_we), int'(we));
        if (we) begin
            chk(req, "rf_waddr", int'(rf_waddr), int'(addr));
            chk(req, "rf_wdata", int'(rf_wdata), int'(data));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        disp_valid = 0; disp_dest = 0; disp_is_mem = 0;
        cmpl_valid = 0; cmpl_tag = 0; cmpl_value = 0;
        mem_exec_req = 0; flush = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "disp_ready", int'(disp_ready), 1);
        chk("R1", "disp_tag", int'(disp_tag), 0);
        chk("R1", "retire_valid", int'(retire_valid), 0);
        chk("R1", "rf_we", int'(rf_we), 0);

        for (int k = 0; k < NVEC; k++) begin
            apply(VECS[k].dv, VECS[k].dd, VECS[k].dm, VECS[k].cv, VECS[k].ct,
                  VECS[k].cval, VECS[k].mr, VECS[k].fl);
            chk("R3", "disp_ready", int'(disp_ready), int'(VECS[k].e_rdy));
            if (VECS[k].e_rdy) chk("R2", "disp_tag", int'(disp_tag), int'(VECS[k].e_tag));
            chk("R6", "mem_exec_grant", int'(mem_exec_grant), int'(VECS[k].mr));
            chk("R5", "retire_valid", int'(retire_valid), int'(VECS[k].e_ret));
            chk("R7", "rf_we", int'(rf_we), int'(VECS[k].e_we));
            if (VECS[k].e_we) begin
                chk("R4", "rf_waddr", int'(rf_waddr), int'(VECS[k].e_addr));
                chk("R4", "rf_wdata", int'(rf_wdata), int'(VECS[k].e_data));
            end
        end

        // R8: flush keeps the oldest slot, drops younger ones (one already finished).
        apply(1, 5'd9, 0, 0, 2'd0, 16'h0, 0, 0);
        chk("R2", "disp_tag", int'(disp_tag), 1);
        apply(1, 5'd10, 0, 1, 2'd1, 16'h9999, 0, 0);
        chk("R2", "disp_tag", int'(disp_tag), 2);
        apply(0, 5'd0, 0, 1, 2'd0, 16'h8888, 0, 0);
        apply(1, 5'd11, 0, 0, 2'd0, 16'h0, 0, 1);
        expect_ret("R8", 0, 0, 5'd0, 16'h0);
        apply(0, 5'd0, 0, 0, 2'd0, 16'h0, 0, 0);
        chk("R8", "disp_tag", int'(disp_tag), 1);
        expect_ret("R8", 1, 1, 5'd8, 16'h8888);
        apply(0, 5'd0, 0, 0, 2'd0, 16'h0, 0, 0);
        expect_ret("R8", 0, 0, 5'd0, 16'h0);
        chk("R8", "disp_ready", int'(disp_ready), 1);

        // R9: completion to an empty slot is ignored.
        apply(0, 5'd0, 0, 1, 2'd1, 16'h5555, 0, 0);
        expect_ret("R9", 0, 0, 5'd0, 16'h0);
        apply(1, 5'd12, 0, 0, 2'd0, 16'h0, 0, 0);
        chk("R9", "disp_tag", int'(disp_tag), 1);
        apply(0, 5'd0, 0, 1, 2'd1, 16'h6666, 0, 0);
        expect_ret("R9", 0, 0, 5'd0, 16'h0);
        apply(0, 5'd0, 0, 0, 2'd0, 16'h0, 0, 0);
        expect_ret("R4", 1, 1, 5'd12, 16'h6666);

        // R8: flush on an empty buffer changes nothing.
        apply(0, 5'd0, 0, 0, 2'd0, 16'h0, 0, 1);
        apply(0, 5'd0, 0, 0, 2'd0, 16'h0, 0, 0);
        chk("R8", "disp_tag", int'(disp_tag), 2);
        chk("R8", "disp_ready", int'(disp_ready), 1);
        expect_ret("R8", 0, 0, 5'd0, 16'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule